// File: doc/BRIEF.md
# I2C Serial Interrupt Flag and Status Unit

This unit keeps the serial interrupt flag and the readable status byte of an I2C controller. The protocol engine announces every state it enters with a one-cycle event that carries a 5-bit state code. The unit latches that code into the status byte. It sets the interrupt flag for every code except the all-ones idle code, which reads back as F8h. The host can clear the flag by writing a zero to it, but it cannot set it. The host also writes an interrupt enable bit. An interrupt request goes out only while both the flag and the enable are set.

While the flag is set, the unit suspends serial transfer by asking the SCL driver to hold the line low. It asks only once SCL has been seen low since the flag rose. It never cuts into a high phase that is already in progress.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, statusOut reads F8h, and siFlag, irqReq and sclHold are all 0.
- R2: An event with a code other than the idle code (all ones) loads the code into statusOut[7:3] and sets siFlag at the next clock edge.
- R3: An event with the idle code makes statusOut read F8h and leaves siFlag at 0 after the next edge. A status of F8h never comes with a pending request.
- R4: irqReq is 1 exactly when siFlag is 1 and the most recently written enable bit is 1.
- R5: A host write with hostWrSi = 0 clears siFlag at the next edge.
- R6: A host write with hostWrSi = 1 leaves siFlag and statusOut unchanged. siFlag never rises without a non-idle event.
- R7: When an event and a host write arrive in the same cycle, the event decides siFlag.
- R8: statusOut[2:0] always reads 0.
- R9: While siFlag is 1, sclHold is 1 in any cycle where sclIn is 0. Once SCL has been seen low with the flag set, sclHold stays 1 until the flag clears. If sclIn has stayed high since the flag rose, sclHold is 0.
- R10: While siFlag is 0, sclHold is 0 whatever sclIn does.
- R11: A host write updates the enable bit and does not change statusOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | State-entry event strobe from the protocol engine |
| evtCode | input | 5 | State code that comes with the event |
| hostWrEn | input | 1 | Host write strobe for the flag and enable bits |
| hostWrSi | input | 1 | Written flag value (0 clears, 1 has no effect) |
| hostWrIntEn | input | 1 | Written interrupt enable value |
| sclIn | input | 1 | Observed SCL line level |
| statusOut | output | 8 | Status byte: code in the upper bits, zeros below |
| siFlag | output | 1 | Serial interrupt flag |
| irqReq | output | 1 | Interrupt request |
| sclHold | output | 1 | Request to hold SCL low |

## Verification
The bench builds the unit with its default parameters: a 5-bit code and 3 zero pad bits. Every one of the 32 codes, including the all-ones idle code, is therefore reachable by random events. Directed cases cover the boundaries: an idle event arriving while the flag is set, an event colliding with a clear write, and SCL going low before, during and after the flag is set. Random sequences mix events, enable writes and SCL toggling, so the request and hold outputs are seen in all of their combinations.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  typedef struct packed {
    logic loadCode;
    logic setSi;
    logic clrSi;
    logic loadEn;
  } strobe_t;
endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter logic [CODE_W-1:0] IDLE_CODE = {CODE_W{1'b1}}
) (
  input  logic              evtValid,
  input  logic [CODE_W-1:0] evtCode,
  input  logic              hostWrEn,
  input  logic              hostWrSi,
  output strobe_t           strb
);
  logic isIdle;

  always_comb begin
    isIdle        = (evtCode == IDLE_CODE);
    strb.loadCode = evtValid;
    strb.setSi    = evtValid && !isIdle;
    // the event wins over a host clear in the same cycle
    strb.clrSi    = (evtValid && isIdle) || (!evtValid && hostWrEn && !hostWrSi);
    strb.loadEn   = hostWrEn;
  end
endmodule

// File: rtl/irq_status_dp.sv
module irq_status_dp
  import irq_status_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int PAD_W = 3,
  parameter logic [CODE_W-1:0] IDLE_CODE = {CODE_W{1'b1}},
  localparam int STAT_W = CODE_W + PAD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [CODE_W-1:0] evtCode,
  input  logic              hostWrIntEn,
  input  logic              sclIn,
  output logic [STAT_W-1:0] statusOut,
  output logic              siFlag,
  output logic              irqReq,
  output logic              sclHold
);
  logic [CODE_W-1:0] codeQ;
  logic              siQ;
  logic              intEnQ;
  logic              lowSeenQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeQ    <= IDLE_CODE;
      siQ      <= 1'b0;
      intEnQ   <= 1'b0;
      lowSeenQ <= 1'b0;
    end else begin
      if (strb.loadCode) codeQ <= evtCode;
      if (strb.setSi) siQ <= 1'b1;
      else if (strb.clrSi) siQ <= 1'b0;
      if (strb.loadEn) intEnQ <= hostWrIntEn;
      // remember a low SCL phase seen while the flag is up
      lowSeenQ <= siQ && (lowSeenQ || !sclIn);
    end
  end

  assign statusOut = {codeQ, {PAD_W{1'b0}}};
  assign siFlag    = siQ;
  assign irqReq    = siQ && intEnQ;
  assign sclHold   = siQ && (lowSeenQ || !sclIn);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int PAD_W = 3,
  parameter logic [CODE_W-1:0] IDLE_CODE = {CODE_W{1'b1}},
  localparam int STAT_W = CODE_W + PAD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic [CODE_W-1:0] evtCode,
  input  logic              hostWrEn,
  input  logic              hostWrSi,
  input  logic              hostWrIntEn,
  input  logic              sclIn,
  output logic [STAT_W-1:0] statusOut,
  output logic              siFlag,
  output logic              irqReq,
  output logic              sclHold
);
  strobe_t strb;

  irq_status_ctrl #(.CODE_W(CODE_W), .IDLE_CODE(IDLE_CODE)) u_ctrl (
    .evtValid(evtValid), .evtCode(evtCode),
    .hostWrEn(hostWrEn), .hostWrSi(hostWrSi), .strb(strb)
  );

  irq_status_dp #(.CODE_W(CODE_W), .PAD_W(PAD_W), .IDLE_CODE(IDLE_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .evtCode(evtCode),
    .hostWrIntEn(hostWrIntEn), .sclIn(sclIn),
    .statusOut(statusOut), .siFlag(siFlag), .irqReq(irqReq), .sclHold(sclHold)
  );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int CODE_W = 5,
  parameter int PAD_W = 3,
  parameter logic [CODE_W-1:0] IDLE_CODE = {CODE_W{1'b1}},
  localparam int STAT_W = CODE_W + PAD_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              evtValid,
  input logic [CODE_W-1:0] evtCode,
  input logic              hostWrEn,
  input logic              hostWrSi,
  input logic              sclIn,
  input logic [STAT_W-1:0] statusOut,
  input logic              siFlag,
  input logic              irqReq,
  input logic              sclHold
);
  localparam logic [STAT_W-1:0] IDLE_STAT = {IDLE_CODE, {PAD_W{1'b0}}};

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    evtValid && evtCode != IDLE_CODE |=> siFlag && statusOut[STAT_W-1:PAD_W] == $past(evtCode));
  a_r3_idle_event: assert property (@(posedge clk) disable iff (!rstN)
    evtValid && evtCode == IDLE_CODE |=> !siFlag && statusOut == IDLE_STAT);
  a_r3_idle_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    statusOut == IDLE_STAT |-> !irqReq);
  a_r4_irq_needs_si: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> siFlag);
  a_r5_host_clear: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn && !hostWrSi && !evtValid |=> !siFlag);
  a_r6_no_sw_set: assert property (@(posedge clk) disable iff (!rstN)
    !siFlag && !(evtValid && evtCode != IDLE_CODE) |=> !siFlag);
  a_r8_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[PAD_W-1:0] == '0);
  a_r9_hold_low: assert property (@(posedge clk) disable iff (!rstN)
    siFlag && !sclIn |-> sclHold);
  a_r10_no_hold: assert property (@(posedge clk) disable iff (!rstN)
    !siFlag |-> !sclHold);
endmodule

bind irq_status_unit irq_status_chk #(.CODE_W(CODE_W), .PAD_W(PAD_W), .IDLE_CODE(IDLE_CODE)) u_chk (
  .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtCode(evtCode),
  .hostWrEn(hostWrEn), .hostWrSi(hostWrSi), .sclIn(sclIn),
  .statusOut(statusOut), .siFlag(siFlag), .irqReq(irqReq), .sclHold(sclHold)
);

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;
  localparam int CW = 5;
  localparam logic [CW-1:0] IDLE = 5'h1F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtValid = 1'b0;
  logic [CW-1:0] evtCode = '0;
  logic hostWrEn = 1'b0, hostWrSi = 1'b0, hostWrIntEn = 1'b0;
  logic sclIn = 1'b1;
  logic [7:0] statusOut;
  logic siFlag, irqReq, sclHold;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  logic [CW-1:0] mCode = IDLE;
  logic mSi = 1'b0, mEn = 1'b0, mLow = 1'b0;

  always #10 clk = ~clk;

  irq_status_unit u_dut (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtCode(evtCode),
    .hostWrEn(hostWrEn), .hostWrSi(hostWrSi), .hostWrIntEn(hostWrIntEn),
    .sclIn(sclIn), .statusOut(statusOut), .siFlag(siFlag),
    .irqReq(irqReq), .sclHold(sclHold)
  );

  function automatic logic nextSi(logic si, logic ev, logic [CW-1:0] c, logic wr, logic wsi);
    if (ev) return c != IDLE;
    if (wr && !wsi) return 1'b0;
    return si;
  endfunction

  function automatic logic expHold(logic si, logic low, logic scl);
    return si && (low || !scl);
  endfunction

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    check(tag, "status R8", statusOut, {mCode, 3'b000});
    check(tag, "siFlag", {7'd0, siFlag}, {7'd0, mSi});
    check(tag, "irqReq R4", {7'd0, irqReq}, {7'd0, mSi & mEn});
    check(tag, "sclHold R10", {7'd0, sclHold}, {7'd0, expHold(mSi, mLow, sclIn)});
  endtask

  // Called just after a negedge: apply inputs, compare, advance the model.
  task automatic cyc(string tag, logic ev, logic [CW-1:0] c, logic wr, logic wsi,
                     logic wen, logic scl);
    evtValid = ev; evtCode = c; hostWrEn = wr; hostWrSi = wsi;
    hostWrIntEn = wen; sclIn = scl;
    #2;
    compareAll(tag);
    @(posedge clk);
    mLow = mSi && (mLow || !scl);
    mSi  = nextSi(mSi, ev, c, wr, wsi);
    if (ev) mCode = c;
    if (wr) mEn = wen;
    @(negedge clk);
  endtask

  task automatic idleCyc(string tag, logic scl);
    cyc(tag, 1'b0, '0, 1'b0, 1'b0, mEn, scl);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int seed = 32'h5EED1;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    #2;
    compareAll("R1 reset");
    check("R1", "status after reset", statusOut, 8'hF8);
    @(negedge clk);
    rstN = 1'b1;

    // R2: non-idle event sets flag and loads code; SCL high so no hold yet
    cyc("R2", 1'b1, 5'h08, 1'b0, 1'b0, 1'b0, 1'b1);
    idleCyc("R2", 1'b1);
    check("R2", "status after event", statusOut, 8'h40);
    // R9: SCL high since set -> no hold; goes low -> hold; back high -> still hold
    idleCyc("R9 high", 1'b1);
    idleCyc("R9 low", 1'b0);
    idleCyc("R9 sticky", 1'b1);
    check("R9", "hold after low seen", {7'd0, sclHold}, 8'd1);
    // R11: enable write changes irq but not status
    cyc("R11", 1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R11", "status unchanged", statusOut, 8'h40);
    check("R4", "irq with enable", {7'd0, irqReq}, 8'd1);
    // R6: writing 1 to SI keeps it set
    cyc("R6", 1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R6", "si kept", {7'd0, siFlag}, 8'd1);
    // R5: clear by writing 0
    cyc("R5", 1'b0, '0, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R5", "si cleared", {7'd0, siFlag}, 8'd0);
    idleCyc("R10", 1'b0);
    check("R10", "no hold with si clear", {7'd0, sclHold}, 8'd0);
    // R6: writing 1 while clear does not set
    cyc("R6", 1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R6", "si not set by write", {7'd0, siFlag}, 8'd0);
    // R7: event with simultaneous clear write -> set
    cyc("R7", 1'b1, 5'h01, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R7", "event wins", {7'd0, siFlag}, 8'd1);
    check("R7", "status code", statusOut, 8'h08);
    // R9: SCL already low when flag set -> immediate hold
    check("R9", "hold when low", {7'd0, sclHold}, 8'd1);
    // R3: idle event while flag set -> F8, flag cleared
    cyc("R3", 1'b1, IDLE, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R3", "idle status", statusOut, 8'hF8);
    check("R3", "idle irq", {7'd0, irqReq}, 8'd0);
    cyc("R3", 1'b1, IDLE, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R3", "idle keeps flag low", {7'd0, siFlag}, 8'd0);
    // highest non-idle code
    cyc("R2", 1'b1, 5'h1E, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R2", "top code", statusOut, 8'hF0);

    // random mix: R2 R4 R5 R9 checked every cycle
    for (int i = 0; i < 400; i++) begin
      logic ev, wr;
      logic [CW-1:0] c;
      ev = ($urandom % 4) == 0;
      c  = (($urandom % 6) == 0) ? IDLE : CW'($urandom);
      wr = ($urandom % 5) == 0;
      cyc("random R2 R4 R5 R9", ev, c, wr, 1'($urandom), 1'($urandom), ($urandom % 3) != 0);
    end
    finishRun();
  end
endmodule